// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and a 32768-word by 8-bit asynchronous static RAM. It takes one single-word read or write request at a time and turns it into the active-low chip-select, output-gate and write-strobe levels the memory needs. It also drives the 15-bit address and the write data, and controls the enable of the host-side tristate driver on the shared 8-bit data bus. The memory itself has no clock and needs no refresh, so every timing limit is met by holding each phase for a whole number of clock cycles.

Each limit is a parameter in nanoseconds. The block rounds it up to cycles using the clock period parameter. A write is the overlap of chip-select low and write-strobe low. Both rise on the same edge, and that edge ends the write. A read holds chip-select and output-gate low for the slowest of the access limits. It samples the data bus on the last edge of that window and returns the byte with a one-cycle valid pulse. A recovery phase after each access keeps the minimum cycle time and lets the bus go high-impedance before the next owner drives it. `req_ready` is high only while the block is idle. A synchronous reset parks all strobes inactive.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: An accepted write (`req_write`=1) drives `mem_ce_n` and `mem_we_n` low together in the next cycle. They stay low for WR_ACT cycles, which is 9 with the defaults: the largest of the write-pulse, select-to-end, address-to-end and data-setup limits, each rounded up over a 4 ns period. `mem_oe_n` stays 1, and `mem_dq_oe` is 1 exactly while `mem_we_n` is 0, with `mem_dq_out` equal to the request data.
- R3: A write ends with `mem_ce_n` and `mem_we_n` rising on the same edge and `mem_dq_oe` falling on that edge. `mem_addr` stays unchanged while `mem_ce_n` is low and until the next accepted request.
- R4: An accepted read (`req_write`=0) drives `mem_ce_n` and `mem_oe_n` low together in the next cycle. They stay low for RD_ACT cycles (12 with defaults: the larger of address access and output-gate access, rounded up), with `mem_we_n` at 1.
- R5: A read samples `mem_dq_in` on the edge that raises the strobes, which is the last edge of the access window. In the following cycle `rd_valid` is 1 for exactly one cycle, and `rd_data` holds the sampled byte.
- R6: `req_ready` is 1 only when no access or recovery is in progress. With defaults, a write keeps it low for 14 cycles after acceptance and a read for 17.
- R7: A request presented while `req_ready` is 0 is ignored. It causes no strobe and no address change after the current access completes.
- R8: At least HZ (5 with defaults, from the 20 ns float time) cycles separate `mem_oe_n` rising from the next rise of `mem_dq_oe`, and `mem_dq_oe` falling from the next fall of `mem_oe_n`.
- R9: `mem_oe_n` and `mem_we_n` are never low at the same time, and `mem_we_n` is low only while `mem_ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address of the request |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Idle; a request is accepted on this cycle's edge |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a fresh read result |
| rd_data | output | 8 | Last byte read |
| mem_addr | output | 15 | Memory address bus |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | 8 | Data for the host-side bus driver |
| mem_dq_oe | output | 1 | Enable of the host-side bus driver |
| mem_dq_in | input | 8 | Data bus as seen by the host |

## Verification
Counting from the accepting edge, the strobes change one cycle later. With defaults, a write's strobes rise 9 edges after acceptance, a read's strobes rise 12 edges after, `rd_valid` follows on the 13th, and `req_ready` returns after 14 edges for a write and 17 for a read. The bench drives requests on falling edges, samples every port on the following falling edges, and counts each low strobe and the index of the valid pulse against these numbers. The bench's memory model presents valid read data only in the last cycle of the read window, so capturing one edge early returns a wrong byte. A monitor measures the turnaround gaps on the strobes and the driver enable.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WR   = 2'd1,
        SEQ_RD   = 2'd2,
        SEQ_REC  = 2'd3
    } seq_state_e;

    // Round a nanosecond limit up to whole clock cycles, never below one.
    function automatic int cyc_ceil(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } cap_s;

    cap_s cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = 1'b0;
        if (capture) begin
            cap_d.data  = dq_in;
            cap_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rd_data  = cap_q.data;
    assign rd_valid = cap_q.valid;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_WC_NS       = 45,
    parameter int T_PWE_NS      = 25,
    parameter int T_SCE_NS      = 35,
    parameter int T_AW_NS       = 25,
    parameter int T_SD_NS       = 20,
    parameter int T_RC_NS       = 45,
    parameter int T_AA_NS       = 45,
    parameter int T_DOE_NS      = 25,
    parameter int T_HZ_NS       = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int HZ_CYC     = cyc_ceil(T_HZ_NS, CLK_PERIOD_NS);
    localparam int WR_ACT_CYC = imax(imax(cyc_ceil(T_PWE_NS, CLK_PERIOD_NS),
                                          cyc_ceil(T_SCE_NS, CLK_PERIOD_NS)),
                                     imax(cyc_ceil(T_AW_NS, CLK_PERIOD_NS),
                                          cyc_ceil(T_SD_NS, CLK_PERIOD_NS)));
    localparam int WR_REC_CYC = imax(imax(cyc_ceil(T_WC_NS, CLK_PERIOD_NS) - WR_ACT_CYC, HZ_CYC), 1);
    localparam int RD_ACT_CYC = imax(cyc_ceil(T_AA_NS, CLK_PERIOD_NS),
                                     cyc_ceil(T_DOE_NS, CLK_PERIOD_NS));
    localparam int RD_REC_CYC = imax(imax(cyc_ceil(T_RC_NS, CLK_PERIOD_NS) - RD_ACT_CYC, HZ_CYC), 1);
    localparam int MAX_CYC    = imax(imax(WR_ACT_CYC, WR_REC_CYC), imax(RD_ACT_CYC, RD_REC_CYC));
    localparam int TMR_W      = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
    } ctl_s;

    localparam ctl_s CTL_RESET = '{st: SEQ_IDLE, addr: '0, wdata: '0,
                                   ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    ctl_s             ctl_d, ctl_q;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             cap_fire;

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_fire = 1'b0;
        unique case (ctl_q.st)
            SEQ_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr = req_addr;
                    ctl_d.ce_n = 1'b0;
                    tmr_load   = 1'b1;
                    if (req_write) begin
                        ctl_d.st    = SEQ_WR;
                        ctl_d.we_n  = 1'b0;
                        ctl_d.dq_oe = 1'b1;
                        ctl_d.wdata = req_wdata;
                        tmr_val     = TMR_W'(WR_ACT_CYC - 1);
                    end else begin
                        ctl_d.st   = SEQ_RD;
                        ctl_d.oe_n = 1'b0;
                        tmr_val    = TMR_W'(RD_ACT_CYC - 1);
                    end
                end
            end
            SEQ_WR: begin
                if (tmr_expired) begin
                    ctl_d.st    = SEQ_REC;
                    ctl_d.ce_n  = 1'b1;
                    ctl_d.we_n  = 1'b1;
                    ctl_d.dq_oe = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = TMR_W'(WR_REC_CYC - 1);
                end
            end
            SEQ_RD: begin
                if (tmr_expired) begin
                    cap_fire   = 1'b1;
                    ctl_d.st   = SEQ_REC;
                    ctl_d.ce_n = 1'b1;
                    ctl_d.oe_n = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = TMR_W'(RD_REC_CYC - 1);
                end
            end
            SEQ_REC: begin
                if (tmr_expired) begin
                    ctl_d.st = SEQ_IDLE;
                end
            end
            default: ctl_d = CTL_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sram_cycle_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .capture  (cap_fire),
        .dq_in    (mem_dq_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign req_ready  = (ctl_q.st == SEQ_IDLE);
    assign mem_addr   = ctl_q.addr;
    assign mem_ce_n   = ctl_q.ce_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_dq_out = ctl_q.wdata;
    assign mem_dq_oe  = ctl_q.dq_oe;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int ADDR_W = 15,
    parameter int WR_ACT = 9,
    parameter int RD_ACT = 12,
    parameter int HZ     = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);
    logic [15:0] we_run, oe_run, since_oe, since_drv;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_run    <= '0;
            oe_run    <= '0;
            since_oe  <= 16'(HZ);
            since_drv <= 16'(HZ);
        end else begin
            we_run   <= !mem_we_n ? we_run + 16'd1 : '0;
            oe_run   <= !mem_oe_n ? oe_run + 16'd1 : '0;
            if (!mem_oe_n) since_oe <= '0;
            else if (since_oe < 16'(HZ)) since_oe <= since_oe + 16'd1;
            if (mem_dq_oe) since_drv <= '0;
            else if (since_drv < 16'(HZ)) since_drv <= since_drv + 16'd1;
        end
    end

    assert_wr_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> we_run == 16'(WR_ACT));
    assert_drv_only_we_R2: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> !mem_we_n);
    assert_wr_end_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_ce_n && !mem_dq_oe));
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
    assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> oe_run == 16'(RD_ACT));
    assert_rd_valid_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> rd_valid);
    assert_rd_single_R5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
    assert_busy_R6: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> !req_ready);
    assert_turn_drv_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> since_oe >= 16'(HZ));
    assert_turn_oe_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> since_drv >= 16'(HZ));
    assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));
    assert_we_in_ce_R9: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_ce_n);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .WR_ACT (WR_ACT_CYC),
    .RD_ACT (RD_ACT_CYC),
    .HZ     (HZ_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
    localparam int WR_ACT = 9;
    localparam int RD_ACT = 12;
    localparam int WR_BUSY = 14;
    localparam int RD_BUSY = 17;
    localparam int HZ = 5;
    localparam int NVEC = 8;
    // {write, addr[14:0], data[7:0]}
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b1, 15'h0000, 8'hA5},
        {1'b1, 15'h7FFF, 8'h3C},
        {1'b1, 15'h1234, 8'hFF},
        {1'b0, 15'h0000, 8'hA5},
        {1'b0, 15'h7FFF, 8'h3C},
        {1'b1, 15'h0000, 8'h00},
        {1'b0, 15'h0000, 8'h00},
        {1'b0, 15'h1234, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  rd_data, mem_dq_out, mem_dq_in;
    logic [14:0] mem_addr;

    int checks = 0, fails = 0, cyc = 0;
    logic [7:0] model [64];
    int rd_age = 0;
    int last_oe_low = -100, last_drv = -100;
    logic prev_dq_oe = 1'b0, prev_oe_n = 1'b1;

    always #2 clk = ~clk;

    sram_async_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: data valid only in the last cycle of the read window.
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && rd_age >= RD_ACT - 1)
                       ? model[mem_addr[5:0]] : 8'hEE;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        rd_age <= (!mem_ce_n && !mem_oe_n) ? rd_age + 1 : 0;
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) model[mem_addr[5:0]] <= mem_dq_out;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual cycle %0d expected under 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Turnaround monitor (R8), sampled on falling edges.
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dq_oe && !prev_dq_oe)
                chk((cyc - last_oe_low - 1) >= HZ, "R8 oe-high before drive", cyc - last_oe_low - 1, HZ);
            if (!mem_oe_n && prev_oe_n)
                chk((cyc - last_drv - 1) >= HZ, "R8 drive-off before oe", cyc - last_drv - 1, HZ);
            if (!mem_oe_n) last_oe_low = cyc;
            if (mem_dq_oe) last_drv = cyc;
        end
        prev_dq_oe = mem_dq_oe;
        prev_oe_n = mem_oe_n;
    end

    task automatic access(input bit wr, input logic [14:0] a, input logic [7:0] d,
                          input logic [7:0] exp_rd, input bit poke);
        int n = 0, we_lo = 0, ce_lo = 0, oe_lo = 0, drv = 0, vcnt = 0, vpos = 0, data_ok = 1;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        do begin
            n++;
            if (poke && (n == 3 || n == 4)) begin
                req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h2222;
            end else req_valid = 1'b0;
            if (!mem_we_n) we_lo++;
            if (!mem_ce_n) ce_lo++;
            if (!mem_oe_n) oe_lo++;
            if (mem_dq_oe) begin
                drv++;
                if (mem_dq_out != d) data_ok = 0;
            end
            if (!mem_ce_n && mem_addr != a) data_ok = 0;
            if (rd_valid) begin vcnt++; vpos = n; end
            @(negedge clk);
        end while (!req_ready);
        req_valid = 1'b0;
        if (wr) begin
            chk(we_lo == WR_ACT, "R2 we low cycles", we_lo, WR_ACT);
            chk(ce_lo == WR_ACT, "R3 ce low equals we low", ce_lo, WR_ACT);
            chk(oe_lo == 0, "R2 oe stays high in write", oe_lo, 0);
            chk(drv == WR_ACT, "R2 driver on only with we", drv, WR_ACT);
            chk(data_ok == 1, "R2 R3 data and address on bus", data_ok, 1);
            chk(n == WR_BUSY, "R6 write busy cycles", n, WR_BUSY);
        end else begin
            chk(oe_lo == RD_ACT && ce_lo == RD_ACT, "R4 read strobe cycles", oe_lo, RD_ACT);
            chk(we_lo == 0 && drv == 0, "R4 we high in read", we_lo + drv, 0);
            chk(vcnt == 1, "R5 single valid pulse", vcnt, 1);
            chk(vpos == RD_ACT + 1, "R5 valid position", vpos, RD_ACT + 1);
            chk(rd_data == exp_rd, "R5 read data", rd_data, exp_rd);
            chk(n == RD_BUSY, "R6 read busy cycles", n, RD_BUSY);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        chk(!mem_dq_oe && !rd_valid && req_ready, "R1 driver off, idle", {mem_dq_oe, rd_valid, req_ready}, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && req_ready, "R1 idle after reset", {mem_ce_n, req_ready}, 3);

        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][23], VEC[i][22:8], VEC[i][7:0], VEC[i][7:0], 1'b0);
        end

        // R7: requests during a busy write are ignored
        access(1'b1, 15'h4A5A, 8'h5A, 8'h00, 1'b1);
        begin
            int stray = 0;
            for (int k = 0; k < 6; k++) begin
                if (!mem_ce_n || mem_addr != 15'h4A5A) stray++;
                @(negedge clk);
            end
            chk(stray == 0, "R7 busy request ignored", stray, 0);
        end
        access(1'b0, 15'h4A5A, 8'h00, 8'h5A, 1'b0);

        // R1: reset in the middle of a read
        req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h1234;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 mid-read reset strobes",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 14);
        chk(req_ready && !rd_valid, "R1 mid-read reset idle", {req_ready, rd_valid}, 2);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        access(1'b0, 15'h1234, 8'h00, 8'hFF, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule